// File: doc/BRIEF.md
# Multi-Mode Load Address Generator

This block forms the effective address of a load from a three-bit mode code and the operands that arrive with it: two register values, a 16-bit immediate, a two-bit scale code and the current program counter. It then fetches the word at that address from a single-port word memory and returns both the address and the loaded word. Register-file reads, instruction decode and write-back are handled elsewhere.

Most modes need one memory read. The two pointer-chasing modes need two reads. The first read fetches a pointer, either from the address in the first register or from the sign-extended immediate. The second read uses that pointer as the final address. A `busy` flag covers the whole operation, and a one-cycle `done` pulse marks the moment the result is ready.

The memory port is a one-cycle `mem_req` pulse carrying `mem_addr`. One or more cycles later the memory answers with a one-cycle `mem_valid` pulse carrying `mem_rdata`. Only one request is outstanding at any time.

Top module: `agu_load`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy`, `mem_req` and `done` are all low.
- R2: Mode 0 (direct) requests the 16-bit immediate, sign-extended to 32 bits.
- R3: Mode 1 (register indirect) requests the first register operand `op_a`.
- R4: Mode 2 (displacement) requests `op_a` plus the sign-extended immediate, wrapping modulo 2^32.
- R5: Mode 3 (indexed) requests `op_a` plus `op_b`, wrapping modulo 2^32.
- R6: Mode 4 first reads at `op_a` and mode 5 first reads at the sign-extended immediate. In both modes the returned word becomes the address of a second read, and it is also reported as `final_addr`.
- R7: Mode 6 (scaled) requests the sign-extended immediate plus `op_a` plus `op_b` times 1, 2, 4 or 8. The multiplier is selected by `scale` = 0, 1, 2 or 3. The sum wraps modulo 2^32.
- R8: Mode 7 (PC-relative) requests `pc` plus the sign-extended immediate, wrapping modulo 2^32.
- R9: `start` is sampled while idle. In the next cycle `busy` rises and `mem_req` pulses for one cycle. A pointer mode issues its second `mem_req` in the cycle after the pointer's `mem_valid`. `busy` stays high until the edge at which the final `mem_valid` is taken.
- R10: In the cycle after the final `mem_valid`, `done` is high for exactly one cycle. In that cycle `busy` is low, `load_data` equals that final `mem_rdata`, and `final_addr` equals the address of the final read.
- R11: `start` is ignored while `busy` is high. The requested addresses and the results of the running operation do not change.
- R12: `mem_valid` is ignored while idle: it produces no `done` and no change to `load_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation (sampled when idle) |
| mode | input | 3 | Addressing mode code, 0 to 7 |
| op_a | input | 32 | First register operand |
| op_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate, sign-extended |
| scale | input | 2 | Scale code for mode 6 |
| pc | input | 32 | Program counter for mode 7 |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_valid | input | 1 | One-cycle read response |
| mem_rdata | input | 32 | Read response word |
| done | output | 1 | One-cycle result-ready pulse |
| final_addr | output | 32 | Address of the final read |
| load_data | output | 32 | Word returned by the final read |

## Verification
The bench keeps a behavioural model that is updated at each rising edge from the inputs seen there. From this model it expects `busy` and the first `mem_req` one cycle after `start` is taken. A pointer mode's second `mem_req` is expected one cycle after the pointer's `mem_valid`, and `done`, `load_data` and `final_addr` one cycle after the final `mem_valid`. The outputs are compared at every falling edge, so each due value is checked in exactly the cycle it is due. Memory latency varies per operation. Stray `start` pulses during an operation and stray `mem_valid` pulses while idle are included to exercise R11 and R12.

// File: rtl/agu_load.sv
module agu_load #(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] op_a,
  input  logic [AW-1:0] op_b,
  input  logic [IW-1:0] imm,
  input  logic [1:0]    scale,
  input  logic [AW-1:0] pc,
  output logic          busy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] final_addr,
  output logic [AW-1:0] load_data
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  state_t        st;
  logic [AW-1:0] addr_q, data_q, imm_x, ea;
  logic          hop_q, done_q;

  assign imm_x = {{(AW-IW){imm[IW-1]}}, imm};

  always_comb begin
    case (mode)
      3'd0:    ea = imm_x;
      3'd1:    ea = op_a;
      3'd2:    ea = op_a + imm_x;
      3'd3:    ea = op_a + op_b;
      3'd4:    ea = op_a;
      3'd5:    ea = imm_x;
      3'd6:    ea = imm_x + op_a + (op_b << scale);
      default: ea = pc + imm_x;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      data_q <= '0;
      hop_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_q <= ea;
          hop_q  <= (mode == 3'd4) || (mode == 3'd5);
          st     <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        default: if (mem_valid) begin
          if (hop_q) begin
            addr_q <= mem_rdata;
            hop_q  <= 1'b0;
            st     <= S_ISSUE;
          end else begin
            data_q <= mem_rdata;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign mem_req    = (st == S_ISSUE);
  assign mem_addr   = addr_q;
  assign final_addr = addr_q;
  assign done       = done_q;
  assign load_data  = data_q;

  p_req_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_req) |=> (mem_req || $stable(mem_addr)));
  p_idle_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !start) |=> !done);

endmodule

// File: tb/tb_agu_load.sv
module tb_agu_load;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] op_a = '0, op_b = '0, pc = '0;
  logic [15:0] imm = '0;
  logic [1:0]  scale = '0;
  logic        busy, mem_req, done;
  logic [31:0] mem_addr, final_addr, load_data;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  agu_load dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_a(op_a),
    .op_b(op_b), .imm(imm), .scale(scale), .pc(pc), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .done(done), .final_addr(final_addr),
    .load_data(load_data));

  int checks = 0, failures = 0, cycles = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a ^ {a[15:0], a[31:16]}) + 32'h1357_9BDF;
  endfunction

  // Bench memory: answers lat cycles after the request edge.
  int          mem_lat = 1;
  int          pend_cnt = 0;
  logic [31:0] pend_addr = '0;
  logic        inject = 1'b0;
  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (inject) begin
      mem_valid <= 1'b1;
      mem_rdata <= 32'hDEAD_0BAD;
    end else if (mem_req) begin
      pend_cnt  <= mem_lat;
      pend_addr <= mem_addr;
    end else if (pend_cnt > 0) begin
      pend_cnt <= pend_cnt - 1;
      if (pend_cnt == 1) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem_word(pend_addr);
      end
    end
  end

  // Behavioural reference model.
  bit          m_busy = 0, m_req = 0, m_done = 0;
  int          m_left = 0;
  logic [31:0] m_addr = '0, m_data = '0, m_final = '0;
  string       m_tag = "R1";

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] ref_ea();
    logic [31:0] sx;
    sx = {{16{imm[15]}}, imm};
    case (mode)
      3'd0: return sx;
      3'd1: return op_a;
      3'd2: return op_a + sx;
      3'd3: return op_a + op_b;
      3'd4: return op_a;
      3'd5: return sx;
      3'd6: return sx + op_a + op_b * (32'd1 << scale);
      default: return pc + sx;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_req = 0; m_done = 0; m_left = 0;
    end else begin
      m_req = 0; m_done = 0;
      if (!m_busy && start) begin
        m_busy = 1;
        m_left = (mode == 3'd4 || mode == 3'd5) ? 2 : 1;
        m_addr = ref_ea();
        m_tag  = mode_tag(mode);
        m_req  = 1;
      end else if (m_busy && mem_valid) begin
        if (m_left == 2) begin
          m_left = 1; m_addr = mem_rdata; m_tag = "R6"; m_req = 1;
        end else begin
          m_busy = 0; m_done = 1; m_data = mem_rdata; m_final = m_addr;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9", "busy", {31'd0, busy}, {31'd0, m_busy});
      chk("R9", "mem_req", {31'd0, mem_req}, {31'd0, m_req});
      if (m_req) chk(m_tag, "mem_addr", mem_addr, m_addr);
      chk(inject ? "R12" : "R10", "done", {31'd0, done}, {31'd0, m_done});
      if (m_done) begin
        chk("R10", "load_data", load_data, m_data);
        chk(m_tag, "final_addr", final_addr, m_final);
      end
    end
  end

  task automatic run_op(input logic [2:0] md, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] im,
                        input logic [1:0] sc, input logic [31:0] p,
                        input int lat, input bit poke);
    @(negedge clk);
    mem_lat = lat;
    mode = md; op_a = a; op_b = b; imm = im; scale = sc; pc = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R11: a second start while busy must be ignored
      mode = 3'd0; imm = 16'h7777; op_a = 32'h1111_1111;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R1", "busy in reset", {31'd0, busy}, 32'd0);
      chk("R1", "mem_req in reset", {31'd0, mem_req}, 32'd0);
      chk("R1", "done in reset", {31'd0, done}, 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", {31'd0, busy}, 32'd0);

    run_op(3'd0, 32'h0, 32'h0, 16'h8004, 2'd0, 32'h0, 1, 0);          // R2 negative imm
    run_op(3'd0, 32'h0, 32'h0, 16'h1234, 2'd0, 32'h0, 2, 0);          // R2
    run_op(3'd1, 32'hCAFE_0010, 32'h0, 16'hFFFF, 2'd0, 32'h0, 1, 0);  // R3
    run_op(3'd2, 32'h0000_1000, 32'h0, 16'hFF00, 2'd0, 32'h0, 3, 0);  // R4
    run_op(3'd2, 32'hFFFF_FFF0, 32'h0, 16'h0020, 2'd0, 32'h0, 1, 0);  // R4 wrap
    run_op(3'd3, 32'h8000_0000, 32'h8000_0004, 16'h0, 2'd0, 32'h0, 2, 0); // R5 wrap
    run_op(3'd4, 32'h0000_4000, 32'h0, 16'h0, 2'd0, 32'h0, 1, 0);     // R6 via register
    run_op(3'd5, 32'h0, 32'h0, 16'hC000, 2'd0, 32'h0, 3, 0);          // R6 via immediate
    for (int s = 0; s < 4; s++)                                        // R7 all scales
      run_op(3'd6, 32'h0000_0100, 32'h0000_0013, 16'hFFF8, s[1:0], 32'h0, 1 + s, 0);
    run_op(3'd6, 32'h7FFF_FFFF, 32'hF000_0000, 16'h0001, 2'd3, 32'h0, 1, 0); // R7 wrap
    run_op(3'd7, 32'h0, 32'h0, 16'hFFF8, 2'd0, 32'h0040_0010, 2, 0);  // R8 backward
    run_op(3'd7, 32'h0, 32'h0, 16'h0100, 2'd0, 32'hFFFF_FF80, 1, 0);  // R8 wrap
    run_op(3'd3, 32'h10, 32'h20, 16'h0, 2'd0, 32'h0, 3, 1);           // R11
    run_op(3'd4, 32'h0000_5550, 32'h0, 16'h0, 2'd0, 32'h0, 3, 1);     // R11 pointer mode

    // R12: stray response while idle
    @(negedge clk);
    inject = 1'b1;
    @(negedge clk);
    inject = 1'b0;
    @(negedge clk);
    chk("R12", "done after stray valid", {31'd0, done}, 32'd0);
    chk("R12", "load_data after stray valid", load_data, m_data);
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule